// File: doc/BRIEF.md
# Duplicate-Free Multi-Input FIFO

This block is a single queue of `DEPTH` entries that is fed by `N_IN` valid-ready input streams and drained through one valid-ready output stream. Its distinguishing rule is that a given input stream may own at most one entry in the queue at any moment. While a payload from stream *i* is still waiting, stream *i* is refused. It becomes eligible again once that payload has been handed out. This spreads queue space evenly over the senders, so one busy stream cannot crowd the others out of the buffer.

In every cycle the block derives a blocking vector from the entries that are currently live. Each live slot sets the bit of the stream it came from. Among the inputs that are valid and not blocked, a fixed-priority picker takes the lowest index. That payload is written at the tail together with its source index. The output always shows the oldest entry, and it carries only the payload: the stored source index stays internal. The asynchronous active-low reset is released through a two-flop synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `uniq_src_fifo`

## Requirements
- R1: While reset is active, and after it, the queue is empty: `out_valid` is 0, and the first cycle after reset grants the lowest valid input, because no stream is blocked.
- R2: At most one bit of `in_ready` is 1 in any cycle. A bit is 1 only for an input whose `in_valid` is 1, and only while the queue holds fewer than `DEPTH` entries.
- R3: Among the valid inputs that own no entry, the one with the smallest index is granted.
- R4: An input that owns a live entry sees `in_ready` = 0 whatever its `in_valid` is, so no two live entries share a source.
- R5: An input whose entry leaves through the output (`out_valid` and `out_ready` both 1 at a clock edge) can be granted in the very next cycle.
- R6: Payloads leave in the order they were accepted, and `out_data` equals the 32-bit value the sender drove, with no source index attached.
- R7: When the queue holds `DEPTH` entries, no input is granted, even in a cycle in which the head entry is being popped.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value in the next cycle.
- R9: Slots outside the live region between head and tail never block an input, even after the pointers have wrapped and stale slots still hold old source indices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | N_IN | Per-input valid, bit i for stream i |
| in_data | input | N_IN*DW | Payloads, stream i in bits [i*DW +: DW] |
| in_ready | output | N_IN | Per-input ready, at most one bit set |
| out_valid | output | 1 | Oldest entry present |
| out_data | output | DW | Payload of the oldest entry |
| out_ready | input | 1 | Downstream accepts the oldest entry |

## Verification
The checker keeps its own record of which streams own a live entry. It sets the bit on each input handshake and clears the bit of the head's source on each output handshake. It therefore assumes that inputs settle between clock edges, and that every run starts from reset. It does not assume that senders hold `in_valid` until they are served. The stimulus drives all inputs on the falling edge. It often withdraws `in_valid` from a waiting stream or raises `in_valid` on a blocked stream, so the checks see senders that behave in both ways.

// File: rtl/usf_pkg.sv
package usf_pkg;

  // Distance of a slot from the head, walking forward around the ring.
  function automatic int ring_off(input int slot, input int head, input int depth);
    if (slot >= head) return slot - head;
    return slot + depth - head;
  endfunction

  // Width of an index that selects one of n items (at least one bit).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/usf_rst_sync.sv
module usf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/usf_store.sv
module usf_store
  import usf_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int DW    = 32,
  parameter int IW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [DW-1:0]       push_data,
  input  logic [IW-1:0]       push_src,
  input  logic                pop,
  output logic [DW-1:0]       head_data,
  output logic [IW-1:0]       head_src,
  output logic                empty,
  output logic                full,
  output logic [DEPTH*IW-1:0] slot_src,
  output logic [DEPTH-1:0]    slot_live
);

  localparam int PW = idx_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] pay_q [DEPTH];
  logic [IW-1:0] src_q [DEPTH];

  logic [PW-1:0] head_q, head_d;
  logic [PW-1:0] tail_q, tail_d;
  logic [CW-1:0] cnt_q,  cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // next-state
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = bump(tail_q);
    if (pop)  head_d = bump(head_q);
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  // pointer and count registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage slots, written with an explicit enable and no reset
  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (tail_q == PW'(j));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        pay_q[j] <= push_data;
        src_q[j] <= push_src;
      end
    end
    assign slot_src[j*IW +: IW] = src_q[j];
  end

  // a slot is live when its distance from the head is below the count
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      slot_live[j] = ring_off(j, int'(head_q), DEPTH) < int'(cnt_q);
    end
  end

  assign head_data = pay_q[head_q];
  assign head_src  = src_q[head_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/usf_owner_mask.sv
module usf_owner_mask #(
  parameter int N_IN  = 5,
  parameter int DEPTH = 5,
  parameter int IW    = 3
) (
  input  logic [DEPTH*IW-1:0] slot_src,
  input  logic [DEPTH-1:0]    slot_live,
  output logic [N_IN-1:0]     owned
);

  for (genvar i = 0; i < N_IN; i++) begin : g_src
    logic [DEPTH-1:0] hit;
    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
      assign hit[j] = slot_live[j] && (slot_src[j*IW +: IW] == IW'(i));
    end
    assign owned[i] = |hit;
  end

endmodule

// File: rtl/usf_pick.sv
module usf_pick #(
  parameter int N_IN = 5,
  parameter int IW   = 3
) (
  input  logic [N_IN-1:0] req,
  input  logic [N_IN-1:0] block,
  output logic [N_IN-1:0] grant,
  output logic [IW-1:0]   grant_idx,
  output logic            grant_any
);

  logic [N_IN-1:0] elig;
  assign elig = req & ~block;

  always_comb begin
    logic taken;
    taken     = 1'b0;
    grant     = '0;
    grant_idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (elig[i] && !taken) begin
        grant[i]  = 1'b1;
        grant_idx = IW'(i);
      end
      taken = taken | elig[i];
    end
  end

  assign grant_any = |elig;

endmodule

// File: rtl/uniq_src_fifo.sv
module uniq_src_fifo
  import usf_pkg::*;
#(
  parameter int N_IN  = 5,
  parameter int DEPTH = 5,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_valid,
  input  logic [N_IN*DW-1:0] in_data,
  output logic [N_IN-1:0]   in_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  input  logic              out_ready
);

  localparam int IW = idx_bits(N_IN);

  logic                rst_sync_n;
  logic [N_IN-1:0]     owned;
  logic [N_IN-1:0]     grant;
  logic [IW-1:0]       grant_idx;
  logic                grant_any;
  logic                push;
  logic                pop;
  logic                empty;
  logic                full;
  logic [DW-1:0]       head_data;
  logic [IW-1:0]       head_src;
  logic [DEPTH*IW-1:0] slot_src;
  logic [DEPTH-1:0]    slot_live;

  usf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  usf_owner_mask #(.N_IN(N_IN), .DEPTH(DEPTH), .IW(IW)) u_mask (
    .slot_src  (slot_src),
    .slot_live (slot_live),
    .owned     (owned)
  );

  usf_pick #(.N_IN(N_IN), .IW(IW)) u_pick (
    .req       (in_valid),
    .block     (owned),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  assign push = grant_any && !full;
  assign pop  = out_valid && out_ready;

  usf_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (push),
    .push_data (in_data[grant_idx*DW +: DW]),
    .push_src  (grant_idx),
    .pop       (pop),
    .head_data (head_data),
    .head_src  (head_src),
    .empty     (empty),
    .full      (full),
    .slot_src  (slot_src),
    .slot_live (slot_live)
  );

  assign in_ready  = grant & {N_IN{!full}};
  assign out_valid = !empty;
  assign out_data  = head_data;

endmodule

// File: rtl/uniq_src_fifo_chk.sv
module uniq_src_fifo_chk #(
  parameter int N_IN = 5,
  parameter int DW   = 32,
  parameter int IW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_IN-1:0] in_valid,
  input logic [N_IN-1:0] in_ready,
  input logic            out_valid,
  input logic [DW-1:0]   out_data,
  input logic            out_ready,
  input logic            full,
  input logic [IW-1:0]   head_src
);

  // independent record of which streams currently own an entry
  logic [N_IN-1:0] own_q;
  logic [N_IN-1:0] lower_elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        if (in_valid[i] && in_ready[i])
          own_q[i] <= 1'b1;
        else if (out_valid && out_ready && head_src == IW'(i))
          own_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      lower_elig[i] = 1'b0;
      for (int j = 0; j < i; j++)
        lower_elig[i] = lower_elig[i] | (in_valid[j] & ~own_q[j]);
    end
  end

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  assert_ready_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  assert_no_grant_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> in_ready == '0);

  assert_hold_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  for (genvar i = 0; i < N_IN; i++) begin : g_src
    assert_no_dup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      own_q[i] |-> !in_ready[i]);

    assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> !lower_elig[i]);

    // R5: a free, valid, top-priority stream is served whenever space exists
    assert_free_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && !own_q[i] && !lower_elig[i] && !full) |-> in_ready[i]);
  end

endmodule

bind uniq_src_fifo uniq_src_fifo_chk #(.N_IN(N_IN), .DW(DW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .full      (full),
  .head_src  (head_src)
);

// File: tb/sim_uniq_src_fifo.sv
module sim_uniq_src_fifo;

  localparam int N  = 5;
  localparam int D  = 5;
  localparam int DW = 32;
  localparam int NV = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    in_ready;
  logic            out_valid;
  logic [DW-1:0]   out_data;
  logic            out_ready = 1'b0;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int i);
    return 32'h5A00_0000 | (32'(i) << 12) | (32'h0000_00C3 ^ 32'(i));
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_drv
    assign in_data[i*DW +: DW] = pat(i);
  end

  uniq_src_fifo #(.N_IN(N), .DEPTH(D), .DW(DW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  // vector: {req[3:0], vin[4:0], ordy, erdy[4:0], eov, esrc[2:0]}
  localparam logic [18:0] VEC [NV] = '{
    {4'd1, 5'b00000, 1'b0, 5'b00000, 1'b0, 3'd0}, // R1 idle after reset
    {4'd3, 5'b11111, 1'b0, 5'b00001, 1'b0, 3'd0}, // R3 all valid, 0 wins
    {4'd4, 5'b11111, 1'b0, 5'b00010, 1'b1, 3'd0}, // R4 0 blocked, 1 wins
    {4'd4, 5'b00001, 1'b0, 5'b00000, 1'b1, 3'd0}, // R4 only blocked input valid
    {4'd3, 5'b10100, 1'b1, 5'b00100, 1'b1, 3'd0}, // R3 pop 0, grant 2
    {4'd5, 5'b00001, 1'b0, 5'b00001, 1'b1, 3'd1}, // R5 0 eligible again
    {4'd3, 5'b11000, 1'b0, 5'b01000, 1'b1, 3'd1}, // R3
    {4'd4, 5'b11111, 1'b0, 5'b10000, 1'b1, 3'd1}, // R4 only 4 free; fills
    {4'd7, 5'b11111, 1'b1, 5'b00000, 1'b1, 3'd1}, // R7 full with pop
    {4'd5, 5'b11111, 1'b0, 5'b00010, 1'b1, 3'd2}, // R5 1 free again
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd2}, // R6 order
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd0}, // R6
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd3}, // R6
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd4}, // R6
    {4'd4, 5'b11111, 1'b1, 5'b00001, 1'b1, 3'd1}, // R4 1 still owned
    {4'd5, 5'b00010, 1'b0, 5'b00010, 1'b1, 3'd0}, // R5
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd0}, // R6
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd1}, // R6
    {4'd9, 5'b11111, 1'b0, 5'b00001, 1'b0, 3'd0}, // R9 stale slots ignored
    {4'd4, 5'b00100, 1'b0, 5'b00100, 1'b1, 3'd0}, // R4
    {4'd3, 5'b11011, 1'b1, 5'b00010, 1'b1, 3'd0}, // R3 0 owned, 2 idle
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd2}, // R6
    {4'd6, 5'b00000, 1'b1, 5'b00000, 1'b1, 3'd1}, // R6
    {4'd9, 5'b00000, 1'b0, 5'b00000, 1'b0, 3'd0}  // R9 empty again
  };

  task automatic check_rdy(input int req, input logic [N-1:0] exp);
    tests++;
    if (in_ready !== exp) begin
      fails++;
      $display("FAIL R%0d in_ready actual=%b expected=%b", req, in_ready, exp);
    end
  endtask

  task automatic check_out(input int req, input logic eov, input int esrc);
    tests++;
    if (out_valid !== eov || (eov && out_data !== pat(esrc))) begin
      fails++;
      $display("FAIL R%0d out actual=%b/%h expected=%b/%h",
               req, out_valid, out_data, eov, eov ? pat(esrc) : '0);
    end
  endtask

  // drive at the falling edge, sample 1 ns later, well before the next rise
  task automatic drive(input logic [N-1:0] vin, input logic ordy);
    @(negedge clk);
    in_valid  = vin;
    out_ready = ordy;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      drive(e[14:10], e[9]);
      check_rdy(int'(e[18:15]), e[8:4]);
      check_out(int'(e[18:15]), e[3], int'(e[2:0]));
    end

    // R8: head held while downstream stalls
    drive(5'b00100, 1'b0);
    check_rdy(8, 5'b00100);
    for (int k = 0; k < 3; k++) begin
      drive(5'b00000, 1'b0);
      check_out(8, 1'b1, 2);
    end
    drive(5'b00000, 1'b1);
    check_out(6, 1'b1, 2);
    drive(5'b00000, 1'b0);
    check_out(6, 1'b0, 0);

    // R1: asynchronous reset in the middle of traffic
    drive(5'b01000, 1'b0);
    check_rdy(2, 5'b01000);
    drive(5'b00000, 1'b0);
    check_out(6, 1'b1, 3);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out(1, 1'b0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    drive(5'b11110, 1'b0);
    check_out(1, 1'b0, 0);
    check_rdy(1, 5'b00010);
    drive(5'b00000, 1'b1);
    check_out(6, 1'b1, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule